// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block resolves read-after-write dependencies between ALU instructions in a five-stage in-order integer pipeline without stalling. It takes three things as inputs. The first is the source register numbers of the instruction now in the execute stage, together with flags from decode that say whether each source is actually read. The second is the destination numbers and register-write flags of the two older instructions in the memory and writeback stages. The third is the three candidate values for each ALU operand.

For each operand it produces a two-bit source select and drives the selected value to the ALU. The result of the instruction one ahead, held after the execute stage, takes priority over the result of the instruction two ahead, held after the memory stage. A producer three ahead needs no bypass, because the register file writes in the first half of the cycle and is read in the second half. The block is purely combinational.

Top module: `fwd_unit`

## Requirements
- R1: When the memory-stage instruction writes a register, its destination is nonzero, and it equals the execute-stage rs number, `selA` is 2'b10.
- R2: When the memory-stage instruction writes a register, its destination is nonzero, and it equals the execute-stage rt number, `selB` is 2'b10.
- R3: When the writeback-stage instruction writes a register, its destination is nonzero, and it matches an operand's source, that operand's select is 2'b01. This applies only when R1/R2 does not hold for that operand.
- R4: When both older stages target the same source register, the select is 2'b10, so the younger result wins.
- R5: A producer whose register-write flag is clear never causes a forward.
- R6: A producer whose destination is register 0 never causes a forward.
- R7: Each operand output equals `rfDataX` for select 2'b00, `memResult` for 2'b10 and `wbResult` for 2'b01. The select 2'b11 is never produced; if it were seen, the mux would fall back to the register file value.
- R8: The two operands are resolved independently. In one cycle they may be forwarded from different stages, or both from the same stage.
- R9: When `exReadsRs` or `exReadsRt` is low, that operand's select is 2'b00 and its output is the register file value, whatever the producers hold.
- R10: With no matching producer in the two older stages, as for a producer three instructions ahead, both selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRs | input | 5 | rs number of the execute-stage instruction |
| exRt | input | 5 | rt number of the execute-stage instruction |
| exReadsRs | input | 1 | execute-stage instruction reads rs |
| exReadsRt | input | 1 | execute-stage instruction reads rt |
| memRd | input | 5 | destination of the memory-stage instruction |
| memRegWrite | input | 1 | memory-stage instruction writes a register |
| wbRd | input | 5 | destination of the writeback-stage instruction |
| wbRegWrite | input | 1 | writeback-stage instruction writes a register |
| rfDataA | input | 32 | register file value for operand A |
| rfDataB | input | 32 | register file value for operand B |
| memResult | input | 32 | ALU result held after the execute stage |
| wbResult | input | 32 | value being written back |
| selA | output | 2 | source select for operand A |
| selB | output | 2 | source select for operand B |
| opA | output | 32 | ALU operand A |
| opB | output | 32 | ALU operand B |

## Verification
The block holds no state, so a wrong select shows in the same cycle as a wrong operand value at `opA` or `opB`. The bench observes it in the very cycle the dependent instruction sits in execute. A bad priority or a missing gate on the write flag, the zero register or the read flag only shows up when the replayed sequence puts the offending producer at distance one or two. The sequences are therefore built so that each such alignment occurs at least once.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF   = 2'b00,
    SRC_WB   = 2'b01,
    SRC_MEM  = 2'b10,
    SRC_RSVD = 2'b11
  } srcSel_e;

  typedef struct packed {
    srcSel_e selA;
    srcSel_e selB;
  } fwdStrobe_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_W         = 5,
  parameter bit GATE_ON_READS = 1'b1
) (
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic             exReadsRs,
  input  logic             exReadsRt,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  output fwdStrobe_t       strobe
);
  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][REG_W-1:0] srcReg;
  logic [NUM_OPS-1:0]            srcRead;
  srcSel_e                       sel [NUM_OPS];

  assign srcReg  = {exRt, exRs};
  assign srcRead = {exReadsRt, exReadsRs};

  // A producer is usable only if it writes a register other than register 0.
  logic memLive, wbLive;
  assign memLive = memRegWrite && (memRd != '0);
  assign wbLive  = wbRegWrite  && (wbRd  != '0);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic readOk, hitMem, hitWb;
    if (GATE_ON_READS) begin : g_gate
      assign readOk = srcRead[i];
    end else begin : g_nogate
      assign readOk = 1'b1;
    end
    assign hitMem = readOk && memLive && (memRd == srcReg[i]);
    assign hitWb  = readOk && wbLive  && (wbRd  == srcReg[i]);

    always_comb begin
      if (hitMem)     sel[i] = SRC_MEM;
      else if (hitWb) sel[i] = SRC_WB;
      else            sel[i] = SRC_RF;
    end
  end

  assign strobe.selA = sel[0];
  assign strobe.selB = sel[1];

  always_comb begin
    AST_NO_RSVD_CODE: assert (strobe.selA != SRC_RSVD && strobe.selB != SRC_RSVD); // R7
    AST_MEM_A_NEEDS_WRITE: assert (strobe.selA != SRC_MEM || memRegWrite); // R5
    AST_WB_A_NEEDS_WRITE: assert (strobe.selA != SRC_WB || wbRegWrite); // R5
    AST_MEM_B_NONZERO: assert (strobe.selB != SRC_MEM || memRd != '0); // R6
    AST_WB_B_NONZERO: assert (strobe.selB != SRC_WB || wbRd != '0); // R6
    AST_WB_LOSES_A: assert (strobe.selA != SRC_WB || !(memRegWrite && memRd != '0 && memRd == exRs)); // R4
    AST_WB_LOSES_B: assert (strobe.selB != SRC_WB || !(memRegWrite && memRd != '0 && memRd == exRt)); // R4
    if (GATE_ON_READS) begin
      AST_UNREAD_A_RF: assert (exReadsRs || strobe.selA == SRC_RF); // R9
      AST_UNREAD_B_RF: assert (exReadsRt || strobe.selB == SRC_RF); // R9
    end
  end
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobe_t        strobe,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic [DATA_W-1:0] memResult,
  input  logic [DATA_W-1:0] wbResult,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);
  localparam int NUM_OPS = 2;

  srcSel_e                        sel [NUM_OPS];
  logic [NUM_OPS-1:0][DATA_W-1:0] rfVal;
  logic [NUM_OPS-1:0][DATA_W-1:0] opVal;

  assign sel[0] = strobe.selA;
  assign sel[1] = strobe.selB;
  assign rfVal  = {rfDataB, rfDataA};

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_mux
    always_comb begin
      case (sel[i])
        SRC_MEM: opVal[i] = memResult;
        SRC_WB:  opVal[i] = wbResult;
        default: opVal[i] = rfVal[i];
      endcase
    end
  end

  assign opA = opVal[0];
  assign opB = opVal[1];

  always_comb begin
    AST_OPA_MEM: assert (strobe.selA != SRC_MEM || opA == memResult); // R7
    AST_OPB_WB: assert (strobe.selB != SRC_WB || opB == wbResult); // R7
    AST_OPA_RF: assert (strobe.selA != SRC_RF || opA == rfDataA); // R7
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W         = 5,
  parameter int DATA_W        = 32,
  parameter bit GATE_ON_READS = 1'b1
) (
  input  logic [REG_W-1:0]  exRs,
  input  logic [REG_W-1:0]  exRt,
  input  logic              exReadsRs,
  input  logic              exReadsRt,
  input  logic [REG_W-1:0]  memRd,
  input  logic              memRegWrite,
  input  logic [REG_W-1:0]  wbRd,
  input  logic              wbRegWrite,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic [DATA_W-1:0] memResult,
  input  logic [DATA_W-1:0] wbResult,
  output logic [1:0]        selA,
  output logic [1:0]        selB,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);
  fwdStrobe_t strobe;

  fwd_ctrl #(.REG_W(REG_W), .GATE_ON_READS(GATE_ON_READS)) ctrl_i (
    .exRs(exRs), .exRt(exRt), .exReadsRs(exReadsRs), .exReadsRt(exReadsRt),
    .memRd(memRd), .memRegWrite(memRegWrite), .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .strobe(strobe)
  );

  fwd_datapath #(.DATA_W(DATA_W)) dp_i (
    .strobe(strobe), .rfDataA(rfDataA), .rfDataB(rfDataB),
    .memResult(memResult), .wbResult(wbResult), .opA(opA), .opB(opB)
  );

  assign selA = strobe.selA;
  assign selB = strobe.selB;
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  exRs = '0, exRt = '0, memRd = '0, wbRd = '0;
  logic        exReadsRs = 1'b0, exReadsRt = 1'b0, memRegWrite = 1'b0, wbRegWrite = 1'b0;
  logic [31:0] rfDataA = '0, rfDataB = '0, memResult = '0, wbResult = '0;
  logic [1:0]  selA, selB;
  logic [31:0] opA, opB;

  fwd_unit dut_i (
    .exRs(exRs), .exRt(exRt), .exReadsRs(exReadsRs), .exReadsRt(exReadsRt),
    .memRd(memRd), .memRegWrite(memRegWrite), .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .rfDataA(rfDataA), .rfDataB(rfDataB), .memResult(memResult), .wbResult(wbResult),
    .selA(selA), .selB(selB), .opA(opA), .opB(opB)
  );

  int testsRun = 0, testsFailed = 0, cycles = 0, instrCount = 0;
  logic [4:0]  exRd = '0;
  logic        exRw = 1'b0;
  logic [31:0] exRes = '0;

  function automatic int expSel(bit reads, int src);
    // Reference priority: one-ahead producer, then two-ahead, else register file.
    if (!reads) return 0;
    if (memRegWrite && memRd != 0 && int'(memRd) == src) return 2;
    if (wbRegWrite && wbRd != 0 && int'(wbRd) == src) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] expOp(int s, logic [31:0] rf);
    if (s == 2) return memResult;
    if (s == 1) return wbResult;
    return rf;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Advance the replay pipeline one instruction and compare at the falling edge.
  task automatic issue(int rs, int rt, bit rRs, bit rRt, int rd, bit rw, string tag);
    int sa, sb;
    @(posedge clk);
    #1;
    wbRd = memRd; wbRegWrite = memRegWrite; wbResult = memResult;
    memRd = exRd; memRegWrite = exRw; memResult = exRes;
    instrCount++;
    exRs = 5'(rs); exRt = 5'(rt); exReadsRs = rRs; exReadsRt = rRt;
    exRd = 5'(rd); exRw = rw; exRes = 32'h5000_0000 + 32'(instrCount);
    rfDataA = 32'hAA00_0000 | 32'(rs); rfDataB = 32'hBB00_0000 | 32'(rt);
    @(negedge clk);
    sa = expSel(rRs, rs);
    sb = expSel(rRt, rt);
    check(tag, "selA", 32'(selA), 32'(sa));
    check(tag, "selB", 32'(selB), 32'(sb));
    check({tag, "/R7"}, "opA", opA, expOp(sa, rfDataA));
    check({tag, "/R7"}, "opB", opB, expOp(sb, rfDataB));
  endtask

  task automatic expectSel(string tag, int a, int b);
    check(tag, "selA fixed", 32'(selA), 32'(a));
    check(tag, "selB fixed", 32'(selB), 32'(b));
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) issue(0, 0, 0, 0, 0, 0, "flush");
  endtask

  initial begin
    @(negedge clk);
    expectSel("reset R5", 0, 0);
    // back-to-back then distance two then distance three
    issue(1, 3, 1, 1, 2, 1, "R10");
    issue(2, 5, 1, 1, 12, 1, "R1");     expectSel("R1", 2, 0);
    issue(6, 2, 1, 1, 13, 1, "R3");     expectSel("R3", 0, 1);
    issue(2, 2, 1, 1, 14, 1, "R10");    expectSel("R10", 0, 0);
    flush();
    issue(1, 1, 1, 1, 7, 1, "R10");
    issue(4, 7, 1, 1, 8, 1, "R2");      expectSel("R2", 0, 2);
    flush();
    // double hazard on the same register
    issue(1, 2, 1, 1, 1, 1, "R4");
    issue(1, 3, 1, 1, 1, 1, "R4");
    issue(1, 4, 1, 1, 1, 1, "R4");      expectSel("R4", 2, 0);
    flush();
    // producer with write flag clear
    issue(0, 0, 0, 0, 9, 0, "R5");
    issue(9, 9, 1, 1, 15, 1, "R5");     expectSel("R5", 0, 0);
    issue(9, 9, 1, 1, 16, 1, "R5");     expectSel("R5", 0, 0);
    flush();
    // writes to register 0
    issue(0, 0, 0, 0, 0, 1, "R6");
    issue(0, 0, 1, 1, 0, 1, "R6");      expectSel("R6", 0, 0);
    issue(0, 0, 1, 1, 17, 1, "R6");     expectSel("R6", 0, 0);
    flush();
    // independent operands, different then same stage
    issue(0, 0, 0, 0, 10, 1, "R8");
    issue(0, 0, 0, 0, 11, 1, "R8");
    issue(11, 10, 1, 1, 20, 1, "R8");   expectSel("R8", 2, 1);
    issue(20, 20, 1, 1, 22, 1, "R8");   expectSel("R8", 2, 2);
    flush();
    // operand not read: load rt is a destination
    issue(0, 0, 0, 0, 21, 1, "R9");
    issue(3, 21, 1, 0, 21, 1, "R9");    expectSel("R9", 0, 0);
    check("R9", "opB", opB, rfDataB);
    issue(21, 5, 0, 1, 23, 1, "R9");    expectSel("R9", 0, 0);
    check("R9", "opA", opA, rfDataA);
    flush();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule